// File: doc/BRIEF.md
# Parallel Port Mode Negotiator with Nibble Receiver

This block is the host side of a bidirectional parallel printer port. On a start pulse it takes an 8-bit extensibility code and runs the handshake that asks the attached peripheral to change mode. It drives the data bus, nStrobe, nAutoFd, nSelectIn and nInit. It watches nAck, Busy, PError, Select and nFault through a synchroniser. The outcome of each attempt is reported as a one-cycle status code.

When the nibble code (0x00) is accepted, the block stays in reverse mode and collects bytes from the peripheral. Each byte arrives as two 4-bit halves on the status lines. Finished bytes leave on a valid/ready stream. Back-pressure follows these rules. A presented byte stays on `rx_data` with `rx_valid` high until the cycle `rx_ready` is high. While a byte waits, the block asks the peripheral for nothing more. Each wait for a peripheral response is bounded by a programmable cycle limit, and every wait state owns its own down-counter.

A start pulse arriving while a negotiation is still running is ignored.

Top module: `p1284_host`

## Requirements
- R1: After reset nStrobe, nAutoFd and nInit are high, nSelectIn is low, `rx_valid`, `neg_done` and `rx_err` are low, and nInit stays high at all times.
- R2: A start pulse in the idle state latches `mode_code` onto `pd_out` and holds it for at least `setup_lim` cycles. Then nSelectIn rises and nAutoFd falls together while nStrobe stays high. `pd_out` does not change while nSelectIn is high.
- R3: If PError, Select and nFault are not all seen high within `resp_lim` cycles after nSelectIn rises, the block reports status 3 (not a 1284 device) and returns to the idle pin levels.
- R4: Once all three lines are high, nStrobe is low for at least `setup_lim` cycles with nAutoFd low and nSelectIn high. nStrobe and nAutoFd then rise in the same cycle.
- R5: If nAck is not seen high within `setup_lim + resp_lim` cycles after that rise, the block reports status 4 (timeout) and returns to idle.
- R6: When nAck is seen high, code 0x00 always gives status 1 (accepted). Any other code gives status 1 if Select is high and status 2 (rejected) if it is low. A rejection returns to idle, while an acceptance keeps nSelectIn high.
- R7: A start pulse while the block holds a negotiated mode gives status 5 (refused). The pulse leaves nSelectIn and nAutoFd unchanged.
- R8: In nibble mode, each half-byte uses this handshake: nAutoFd falls, the block waits for nAck low, captures the half, raises nAutoFd and waits for nAck high. Each byte takes two such handshakes.
- R9: The captured half maps nFault to bit 0, Select to bit 1, PError to bit 2 and Busy to bit 3. The first half is the low half of the byte.
- R10: The wait for a byte's first nAck low is bounded by `idle_lim`, and every later wait by `resp_lim`. On expiry the block pulses `rx_err` with nAutoFd high and discards the partial byte. It requests again only once nAck is seen high.
- R11: `rx_data` stays stable with `rx_valid` high until `rx_ready`. While a byte waits unaccepted, nAutoFd is not lowered.
- R12: After a non-nibble code is accepted, nSelectIn, nAutoFd and nStrobe stay high and no half-byte is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_lim | input | CNT_W | Setup interval in cycles |
| resp_lim | input | CNT_W | Peripheral response limit in cycles |
| idle_lim | input | CNT_W | Limit for the first half-byte of a byte |
| start | input | 1 | Request a negotiation |
| mode_code | input | 8 | Extensibility code to request |
| neg_done | output | 1 | One-cycle status strobe |
| neg_status | output | 3 | 1 accepted, 2 rejected, 3 not 1284, 4 timeout, 5 refused |
| pd_out | output | 8 | Data bus towards the peripheral |
| nstrobe_o | output | 1 | nStrobe level |
| nautofd_o | output | 1 | nAutoFd level |
| nselectin_o | output | 1 | nSelectIn level |
| ninit_o | output | 1 | nInit level |
| nack_i | input | 1 | nAck level |
| busy_i | input | 1 | Busy level |
| perror_i | input | 1 | PError level |
| select_i | input | 1 | Select level |
| nfault_i | input | 1 | nFault level |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |
| rx_err | output | 1 | One-cycle pulse on a reverse handshake timeout |

## Verification
Some properties are checked on every cycle. nStrobe only goes low under nAutoFd low and nSelectIn high. The data bus holds still while nSelectIn is high. Any fall of nSelectIn coincides with a failure status, and an acceptance leaves the lines released. A stalled byte keeps both its data and nAutoFd high, and a receive error always leaves nAutoFd high. Only the scenarios can show the rest: the decision among the five status codes, the interval lengths, the nibble bit order, the choice of the long or short limit per wait, and recovery after a discarded byte.

// File: rtl/p1284_pkg.sv
package p1284_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MODE_SETUP, ST_WAIT_ID, ST_LATCH, ST_WAIT_REPLY,
    ST_PARKED, ST_REV_READY, ST_LO_REQ, ST_LO_REL, ST_HI_REQ, ST_HI_REL
  } ph_t;

  typedef enum logic [2:0] {
    NS_NONE = 3'd0, NS_ACCEPT = 3'd1, NS_REJECT = 3'd2,
    NS_NOT1284 = 3'd3, NS_TIMEOUT = 3'd4, NS_REFUSED = 3'd5
  } neg_code_t;

  typedef enum logic [1:0] {LIM_SETUP, LIM_RESP, LIM_SUM, LIM_IDLE} lim_sel_t;

  localparam int NUM_TIMED = 8;
  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 2 * NIB_W;
  localparam logic [BYTE_W-1:0] NIBBLE_CODE = '0;

  function automatic ph_t timed_phase(input int idx);
    case (idx)
      0:       return ST_MODE_SETUP;
      1:       return ST_WAIT_ID;
      2:       return ST_LATCH;
      3:       return ST_WAIT_REPLY;
      4:       return ST_LO_REQ;
      5:       return ST_LO_REL;
      6:       return ST_HI_REQ;
      default: return ST_HI_REL;
    endcase
  endfunction

  function automatic lim_sel_t timed_limit(input int idx);
    case (idx)
      0, 2:    return LIM_SETUP;
      3:       return LIM_SUM;
      4:       return LIM_IDLE;
      default: return LIM_RESP;
    endcase
  endfunction

endpackage

// File: rtl/p1284_sync.sv
module p1284_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/p1284_wait_timer.sv
module p1284_wait_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (arm)                cnt <= limit;
    else if (run && cnt != '0)   cnt <= cnt - W'(1);
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/p1284_nib_pack.sv
module p1284_nib_pack
  import p1284_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_lo,
  input  logic              take_hi,
  input  logic [NIB_W-1:0]  nib,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  logic [NIB_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take_lo) lo_q <= nib;
      if (take_hi) begin
        out_data  <= {nib, lo_q};
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/p1284_host.sv
module p1284_host
  import p1284_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] setup_lim,
  input  logic [CNT_W-1:0] resp_lim,
  input  logic [CNT_W-1:0] idle_lim,
  input  logic             start,
  input  logic [7:0]       mode_code,
  output logic             neg_done,
  output logic [2:0]       neg_status,
  output logic [7:0]       pd_out,
  output logic             nstrobe_o,
  output logic             nautofd_o,
  output logic             nselectin_o,
  output logic             ninit_o,
  input  logic             nack_i,
  input  logic             busy_i,
  input  logic             perror_i,
  input  logic             select_i,
  input  logic             nfault_i,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_err
);
  localparam int LIM_W = CNT_W + 1;
  localparam int IN_W  = 5;

  // status line synchroniser: idle levels nAck high, nFault high
  logic [IN_W-1:0] s_vec;
  logic s_nack, s_busy, s_perror, s_select, s_nfault;

  p1284_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b10001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({nack_i, busy_i, perror_i, select_i, nfault_i}),
    .q    (s_vec)
  );
  assign {s_nack, s_busy, s_perror, s_select, s_nfault} = s_vec;

  ph_t        st_q, st_d;
  neg_code_t  code_d;
  logic       done_d, err_d, take_lo, take_hi, latch_mode;
  logic [7:0] mode_q;
  logic       nibble_q;
  logic [NUM_TIMED-1:0] tm_exp;
  logic       tmo;
  logic       negotiated;

  assign tmo      = |tm_exp;
  assign nibble_q = (mode_q == NIBBLE_CODE);

  // one down-counter per timed phase
  for (genvar g = 0; g < NUM_TIMED; g++) begin : g_tm
    localparam ph_t      PH  = timed_phase(g);
    localparam lim_sel_t SEL = timed_limit(g);
    logic [LIM_W-1:0] lim;
    if (SEL == LIM_SETUP) begin : g_setup
      assign lim = {1'b0, setup_lim};
    end else if (SEL == LIM_RESP) begin : g_resp
      assign lim = {1'b0, resp_lim};
    end else if (SEL == LIM_SUM) begin : g_sum
      assign lim = {1'b0, setup_lim} + {1'b0, resp_lim};
    end else begin : g_idle
      assign lim = {1'b0, idle_lim};
    end
    p1284_wait_timer #(.W(LIM_W)) u_tm (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    ((st_d == PH) && (st_q != PH)),
      .run    (st_q == PH),
      .limit  (lim),
      .expired(tm_exp[g])
    );
  end

  assign negotiated = (st_q == ST_PARKED) || (st_q == ST_REV_READY) ||
                      (st_q == ST_LO_REQ) || (st_q == ST_LO_REL) ||
                      (st_q == ST_HI_REQ) || (st_q == ST_HI_REL);

  always_comb begin
    st_d       = st_q;
    done_d     = 1'b0;
    code_d     = NS_NONE;
    err_d      = 1'b0;
    take_lo    = 1'b0;
    take_hi    = 1'b0;
    latch_mode = 1'b0;
    if (start && negotiated) begin
      done_d = 1'b1;
      code_d = NS_REFUSED;
    end
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          latch_mode = 1'b1;
          st_d       = ST_MODE_SETUP;
        end
      end
      ST_MODE_SETUP: if (tmo) st_d = ST_WAIT_ID;
      ST_WAIT_ID: begin
        if (s_perror && s_select && s_nfault) begin
          st_d = ST_LATCH;
        end else if (tmo) begin
          done_d = 1'b1;
          code_d = NS_NOT1284;
          st_d   = ST_IDLE;
        end
      end
      ST_LATCH: if (tmo) st_d = ST_WAIT_REPLY;
      ST_WAIT_REPLY: begin
        if (s_nack) begin
          done_d = 1'b1;
          if (nibble_q || s_select) begin
            code_d = NS_ACCEPT;
            st_d   = nibble_q ? ST_REV_READY : ST_PARKED;
          end else begin
            code_d = NS_REJECT;
            st_d   = ST_IDLE;
          end
        end else if (tmo) begin
          done_d = 1'b1;
          code_d = NS_TIMEOUT;
          st_d   = ST_IDLE;
        end
      end
      ST_PARKED: st_d = ST_PARKED;
      ST_REV_READY: begin
        if (s_nack && (!rx_valid || rx_ready)) st_d = ST_LO_REQ;
      end
      ST_LO_REQ: begin
        if (!s_nack) begin
          take_lo = 1'b1;
          st_d    = ST_LO_REL;
        end else if (tmo) begin
          err_d = 1'b1;
          st_d  = ST_REV_READY;
        end
      end
      ST_LO_REL: begin
        if (s_nack) begin
          st_d = ST_HI_REQ;
        end else if (tmo) begin
          err_d = 1'b1;
          st_d  = ST_REV_READY;
        end
      end
      ST_HI_REQ: begin
        if (!s_nack) begin
          take_hi = 1'b1;
          st_d    = ST_HI_REL;
        end else if (tmo) begin
          err_d = 1'b1;
          st_d  = ST_REV_READY;
        end
      end
      ST_HI_REL: begin
        if (s_nack) begin
          st_d = ST_REV_READY;
        end else if (tmo) begin
          err_d = 1'b1;
          st_d  = ST_REV_READY;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mode_q     <= '0;
      neg_done   <= 1'b0;
      neg_status <= 3'd0;
      rx_err     <= 1'b0;
    end else begin
      st_q       <= st_d;
      neg_done   <= done_d;
      neg_status <= code_d;
      rx_err     <= err_d;
      if (latch_mode) mode_q <= mode_code;
    end
  end

  // line levels per phase
  always_comb begin
    nstrobe_o   = 1'b1;
    nautofd_o   = 1'b1;
    nselectin_o = 1'b1;
    case (st_q)
      ST_IDLE, ST_MODE_SETUP: nselectin_o = 1'b0;
      ST_WAIT_ID:             nautofd_o   = 1'b0;
      ST_LATCH: begin
        nautofd_o = 1'b0;
        nstrobe_o = 1'b0;
      end
      ST_LO_REQ, ST_HI_REQ:   nautofd_o   = 1'b0;
      default: ;
    endcase
  end

  assign ninit_o = 1'b1;
  assign pd_out  = mode_q;

  p1284_nib_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_lo  (take_lo),
    .take_hi  (take_hi),
    .nib      ({s_busy, s_perror, s_select, s_nfault}),
    .out_ready(rx_ready),
    .out_valid(rx_valid),
    .out_data (rx_data)
  );
endmodule

// File: rtl/p1284_host_chk.sv
module p1284_host_chk
  import p1284_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       neg_done,
  input logic [2:0] neg_status,
  input logic [7:0] pd_out,
  input logic       nstrobe_o,
  input logic       nautofd_o,
  input logic       nselectin_o,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_err
);
  // R4
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nstrobe_o |-> (!nautofd_o && nselectin_o));

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nselectin_o && $past(nselectin_o)) |-> $stable(pd_out));

  // R3
  fall_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nselectin_o) |-> (neg_done && (neg_status == NS_REJECT ||
      neg_status == NS_NOT1284 || neg_status == NS_TIMEOUT)));

  // R6
  accept_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_done && neg_status == NS_ACCEPT) |-> (nselectin_o && nautofd_o && nstrobe_o));

  // R7
  refuse_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_done && neg_status == NS_REFUSED) |-> (nselectin_o && $stable(nselectin_o)));

  // R11
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R11
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && nautofd_o) |=> nautofd_o);

  // R10
  err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (nautofd_o && nselectin_o));
endmodule

bind p1284_host p1284_host_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .neg_done   (neg_done),
  .neg_status (neg_status),
  .pd_out     (pd_out),
  .nstrobe_o  (nstrobe_o),
  .nautofd_o  (nautofd_o),
  .nselectin_o(nselectin_o),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .rx_err     (rx_err)
);

// File: tb/p1284_host_test.sv
module p1284_host_test;
  localparam int CW    = 16;
  localparam int SETUP = 3;
  localparam int RESP  = 20;
  localparam int IDLE  = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mode_code = 8'h00;
  logic neg_done;
  logic [2:0] neg_status;
  logic [7:0] pd_out;
  logic nstrobe_o, nautofd_o, nselectin_o, ninit_o;
  logic nack_i = 1'b1, busy_i = 1'b0, perror_i = 1'b0, select_i = 1'b0, nfault_i = 1'b1;
  logic rx_valid;
  logic rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic rx_err;

  always #10 clk = ~clk;

  p1284_host #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .setup_lim(CW'(SETUP)), .resp_lim(CW'(RESP)), .idle_lim(CW'(IDLE)),
    .start(start), .mode_code(mode_code),
    .neg_done(neg_done), .neg_status(neg_status), .pd_out(pd_out),
    .nstrobe_o(nstrobe_o), .nautofd_o(nautofd_o), .nselectin_o(nselectin_o), .ninit_o(ninit_o),
    .nack_i(nack_i), .busy_i(busy_i), .perror_i(perror_i), .select_i(select_i), .nfault_i(nfault_i),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [2:0] exp_codes[$];
  string      code_tags[$];
  logic [7:0] exp_bytes[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines_idle();
    nack_i = 1'b1; busy_i = 1'b0; perror_i = 1'b0; select_i = 1'b0; nfault_i = 1'b1;
  endtask

  task automatic pulse_start(input logic [7:0] m);
    mode_code = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_afd(input logic v, input int lim, output int n);
    n = 0;
    while (nautofd_o !== v) begin
      if (n >= lim) begin
        n = -1;
        return;
      end
      @(negedge clk);
      n++;
    end
  endtask

  task automatic drain();
    while (exp_codes.size() != 0 || exp_bytes.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (neg_done) begin
        if (exp_codes.size() == 0) check(1'b0, "R6", "unexpected status", neg_status, 0);
        else begin
          automatic logic [2:0] e = exp_codes.pop_front();
          automatic string t = code_tags.pop_front();
          check(neg_status == e, t, "status code", neg_status, e);
        end
      end
      if (rx_valid && rx_ready) begin
        if (exp_bytes.size() == 0) check(1'b0, "R9", "unexpected byte", rx_data, 0);
        else begin
          automatic logic [7:0] eb = exp_bytes.pop_front();
          check(rx_data == eb, "R9", "received byte", rx_data, eb);
        end
      end
    end
  end

  task automatic expect_code(input logic [2:0] c, input string t);
    exp_codes.push_back(c);
    code_tags.push_back(t);
  endtask

  // peripheral side of a negotiation
  task automatic periph_neg(input bit respond, input bit sel_final, input bit ack_back);
    int n;
    while (!(nselectin_o === 1'b1 && nautofd_o === 1'b0)) @(negedge clk);
    if (!respond) return;
    cyc(1);
    perror_i = 1'b1; select_i = 1'b1; nfault_i = 1'b1;
    while (nstrobe_o !== 1'b0) @(negedge clk);
    check(nautofd_o == 1'b0, "R4", "nAutoFd during strobe", nautofd_o, 0);
    nack_i = 1'b0;
    select_i = sel_final;
    n = 0;
    while (nstrobe_o === 1'b0) begin @(negedge clk); n++; end
    check(n >= SETUP, "R4", "strobe low cycles", n, SETUP);
    check(nautofd_o == 1'b1, "R4", "nAutoFd rises with nStrobe", nautofd_o, 1);
    if (ack_back) begin
      cyc(2);
      nack_i = 1'b1;
    end
  endtask

  // peripheral sends one byte as two halves
  task automatic send_byte(input logic [7:0] b);
    int n;
    wait_afd(1'b0, IDLE + 20, n);
    check(n >= 0 && nselectin_o && nstrobe_o, "R8", "low half request", n, 0);
    {busy_i, perror_i, select_i, nfault_i} = b[3:0];
    cyc(1);
    nack_i = 1'b0;
    wait_afd(1'b1, RESP + 20, n);
    check(n >= 0, "R8", "release after low half", n, 0);
    nack_i = 1'b1;
    wait_afd(1'b0, RESP + 20, n);
    check(n >= 0, "R8", "high half request", n, 0);
    {busy_i, perror_i, select_i, nfault_i} = b[7:4];
    cyc(1);
    nack_i = 1'b0;
    wait_afd(1'b1, RESP + 20, n);
    check(n >= 0, "R8", "release after high half", n, 0);
    nack_i = 1'b1;
    cyc(1);
  endtask

  initial begin
    int n;
    bit stayed;
    logic [7:0] held;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset levels
    check(nstrobe_o && nautofd_o && ninit_o && !nselectin_o, "R1", "idle lines",
          {nstrobe_o, nautofd_o, ninit_o, nselectin_o}, 4'b1110);
    check(!rx_valid && !neg_done && !rx_err, "R1", "idle outputs",
          {rx_valid, neg_done, rx_err}, 0);

    // R2 / R3: silent peripheral
    expect_code(3'd3, "R3");
    pulse_start(8'h10);
    n = 1;
    while (nselectin_o !== 1'b1) begin @(negedge clk); n++; end
    check(n >= SETUP && n <= SETUP + 3, "R2", "setup before nSelectIn", n, SETUP + 1);
    check(pd_out == 8'h10 && !nautofd_o && nstrobe_o, "R2", "event 1 lines",
          {pd_out, nautofd_o, nstrobe_o}, {8'h10, 2'b01});
    n = 0;
    while (nselectin_o === 1'b1) begin @(negedge clk); n++; end
    check(n >= RESP && n <= RESP + 4, "R3", "id wait length", n, RESP + 1);
    check(nautofd_o && nstrobe_o && ninit_o, "R3", "back to idle lines",
          {nautofd_o, nstrobe_o, ninit_o}, 3'b111);
    drain();
    lines_idle(); cyc(5);

    // R5: nAck never returns
    expect_code(3'd4, "R5");
    pulse_start(8'h10);
    periph_neg(1'b1, 1'b1, 1'b0);
    n = 0;
    while (nselectin_o === 1'b1) begin @(negedge clk); n++; end
    check(n >= SETUP + RESP && n <= SETUP + RESP + 4, "R5", "reply wait length", n, SETUP + RESP + 1);
    drain();
    lines_idle(); cyc(5);

    // R6: rejected code
    expect_code(3'd2, "R6");
    pulse_start(8'h10);
    periph_neg(1'b1, 1'b0, 1'b1);
    drain();
    cyc(2);
    check(nselectin_o == 1'b0, "R6", "idle after reject", nselectin_o, 0);
    lines_idle(); cyc(5);

    // R6 / R12 / R7: non-nibble acceptance
    expect_code(3'd1, "R6");
    pulse_start(8'h30);
    periph_neg(1'b1, 1'b1, 1'b1);
    drain();
    stayed = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!(nautofd_o && nselectin_o && nstrobe_o)) stayed = 1'b0;
    end
    check(stayed, "R12", "lines held after non-nibble accept", stayed, 1);
    expect_code(3'd5, "R7");
    pulse_start(8'h00);
    drain();
    cyc(3);
    check(nselectin_o && nautofd_o, "R7", "lines after refusal parked",
          {nselectin_o, nautofd_o}, 2'b11);

    rst_n = 1'b0;
    lines_idle();
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R6 nibble code accepted with Select low
    expect_code(3'd1, "R6");
    pulse_start(8'h00);
    periph_neg(1'b1, 1'b0, 1'b1);
    drain();
    wait_afd(1'b0, 20, n);
    check(n >= 0, "R8", "first request after accept", n, 0);
    expect_code(3'd5, "R7");
    pulse_start(8'h10);
    drain();
    cyc(3);
    check(nselectin_o && !nautofd_o, "R7", "lines after refusal in reverse",
          {nselectin_o, nautofd_o}, 2'b10);

    // R8 / R9 bytes
    foreach (held[i]) ;
    exp_bytes.push_back(8'hA5); send_byte(8'hA5);
    exp_bytes.push_back(8'h3C); send_byte(8'h3C);
    exp_bytes.push_back(8'h00); send_byte(8'h00);
    exp_bytes.push_back(8'hFF); send_byte(8'hFF);
    exp_bytes.push_back(8'h5A); send_byte(8'h5A);
    drain();

    // R11 back-pressure
    rx_ready = 1'b0;
    exp_bytes.push_back(8'h96);
    send_byte(8'h96);
    cyc(4);
    check(rx_valid && rx_data == 8'h96, "R11", "byte presented", rx_data, 8'h96);
    held = rx_data;
    stayed = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!nautofd_o || rx_data != held || !rx_valid) stayed = 1'b0;
    end
    check(stayed, "R11", "no request while stalled", stayed, 1);
    rx_ready = 1'b1;
    wait_afd(1'b0, 10, n);
    check(n >= 0, "R11", "request after drain", n, 0);

    // R10 long limit on first half
    n = 0;
    while (rx_err !== 1'b1) begin @(negedge clk); n++; end
    check(n >= IDLE && n <= IDLE + 3, "R10", "first half limit", n, IDLE + 1);
    check(nautofd_o == 1'b1, "R10", "nAutoFd at error", nautofd_o, 1);

    // R10 short limit on a later wait
    wait_afd(1'b0, 10, n);
    {busy_i, perror_i, select_i, nfault_i} = 4'h7;
    cyc(1);
    nack_i = 1'b0;
    wait_afd(1'b1, RESP + 20, n);
    n = 0;
    while (rx_err !== 1'b1) begin @(negedge clk); n++; end
    check(n >= RESP && n <= RESP + 3, "R10", "later wait limit", n, RESP + 1);
    cyc(5);
    check(nautofd_o == 1'b1, "R10", "no request while nAck low", nautofd_o, 1);
    nack_i = 1'b1;
    exp_bytes.push_back(8'hC3);
    send_byte(8'hC3);
    drain();
    cyc(10);
    check(exp_bytes.size() == 0 && exp_codes.size() == 0, "R9", "scoreboard empty",
          exp_bytes.size() + exp_codes.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule